// File: doc/BRIEF.md
# Sound Voice Control Register Bank

This block holds the control settings of 64 sample-playback voices. Software writes 16-bit words through one write port. The port carries a window select, which picks voices 0 to 31 or voices 32 to 63, and a byte offset inside that window, where each voice takes a 128-byte slot. Each write is decoded into fields that the playback engine reads directly on per-voice output buses:

- sample start address
- loop enable
- sample format
- loop start and loop end points
- playback rate
- pan
- level

The playback rate comes from a compact floating-point pitch word. A three-stage multicycle converter turns that word into samples per second relative to 44100. While a conversion is in flight, a per-voice valid flag is held low.

Each voice keeps a key flag from its config word. A config write with its trigger bit set sweeps all voices in one cycle. Each voice then gets a one-cycle start strobe if its key flag is set, or a stop strobe if it is clear, and its run state is latched to match.

Top module: `snd_voice_regs`

## Requirements
- R1: The voice number is the offset divided by 128, plus 32 when `wr_win_i` is 1. The register within the voice is the offset modulo 128.
- R2: A write at register 0x00 stores data bits 4:0 as start-address bits 20:16 and data bit 9 as loop enable. A write at 0x04 stores start-address bits 15:0.
- R3: A write at register 0x00 sets the format from data bits 8:7. Value 0 gives output code 0 (16-bit PCM), value 1 gives code 1 (8-bit PCM), and values 2 or 3 give code 2 (ADPCM).
- R4: Register 0x08 stores the 16-bit loop start and register 0x0C stores the 16-bit loop end.
- R5: At register 0x18 the pitch word holds m = bits 9:0, e = bits 13:11 and a negative flag in bit 14. With the flag clear, the rate is (44100<<e) + ((44100*m)>>(10-e)). With the flag set and s = 8-e, the rate is (44100>>s) + ((44100*m)>>(10+s)).
- R6: After a pitch write, that voice's rate valid is low from the next cycle. The new rate appears with valid high after the third rising edge counted from the write edge. If a newer pitch write to the same voice is still in flight, the older result does not raise valid.
- R7: Register 0x24 sets pan from data bits 4:0. A value v of 15 or less is stored as 15-v, and larger values are stored unchanged.
- R8: Register 0x28 sets the level to the larger of data bits 7:0 and data bits 15:8.
- R9: A write at register 0x00 with data bit 15 set triggers a sweep. On the next cycle, every voice whose key flag (bit 14 of its latest config write, including the write that triggers) is 1 pulses `key_start_o`, and every other voice pulses `key_stop_o`. `run_o` then equals the key flags. Without a trigger, both strobes stay 0 and `run_o` holds.
- R10: Writes to any other register offset change no output and raise no strobe.
- R11: After reset, every field, `run_o`, every strobe and every rate valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_win_i | input | 1 | Window select: 0 for voices 0-31, 1 for voices 32-63 |
| wr_off_i | input | 12 | Byte offset in the window |
| wr_data_i | input | 16 | Write data |
| start_addr_o | output | 64*21 | Start address per voice |
| loop_en_o | output | 64 | Loop enable per voice |
| fmt_o | output | 64*2 | Format code per voice |
| loop_start_o | output | 64*16 | Loop start per voice |
| loop_end_o | output | 64*16 | Loop end per voice |
| rate_o | output | 64*24 | Playback rate per voice |
| rate_vld_o | output | 64 | Rate valid per voice |
| pan_o | output | 64*5 | Pan per voice |
| level_o | output | 64*8 | Level per voice |
| run_o | output | 64 | Run state per voice |
| key_start_o | output | 64 | Start strobe per voice |
| key_stop_o | output | 64 | Stop strobe per voice |

## Verification
The bench targets the pitch conversion at both exponent extremes, with the mantissa at 0 and at 1023. A design that mishandles the negative-exponent shift, or takes the wrong width for the product, returns rates far from 344, 22050 or 11284087.

It also checks pan at the 15/16 boundary, and the 8-bit versus ADPCM format codes. A sign or compare error there shows up as a mirrored pan or as format code 3.

For the key sweep, the bench checks that the triggering write's own key bit is used, not the old stored one. A design that reads stale state would miss that voice's start strobe.

Two back-to-back pitch writes to the same voice check that the older result does not raise valid early. An unlisted offset written with all ones must leave every field and strobe untouched.

// File: rtl/snd_voice_pkg.sv
package snd_voice_pkg;
  localparam int STRIDE_W = 7;
  localparam int ADDR_W   = 21;
  localparam int HALF_W   = 16;
  localparam int PAN_W    = 5;
  localparam int LVL_W    = 8;

  localparam logic [STRIDE_W-1:0] REG_CFG    = 7'h00;
  localparam logic [STRIDE_W-1:0] REG_SA_LO  = 7'h04;
  localparam logic [STRIDE_W-1:0] REG_LSTART = 7'h08;
  localparam logic [STRIDE_W-1:0] REG_LEND   = 7'h0C;
  localparam logic [STRIDE_W-1:0] REG_PITCH  = 7'h18;
  localparam logic [STRIDE_W-1:0] REG_PAN    = 7'h24;
  localparam logic [STRIDE_W-1:0] REG_LEVEL  = 7'h28;

  typedef enum logic [1:0] {
    FMT_PCM16 = 2'd0,
    FMT_PCM8  = 2'd1,
    FMT_ADPCM = 2'd2
  } smp_fmt_e;

  function automatic smp_fmt_e fmt_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return FMT_PCM16;
      2'd1:    return FMT_PCM8;
      default: return FMT_ADPCM;
    endcase
  endfunction

  function automatic logic [PAN_W-1:0] pan_map(input logic [PAN_W-1:0] v);
    return (v <= 5'd15) ? (5'd15 - v) : v;
  endfunction

  function automatic logic [LVL_W-1:0] level_pick(input logic [15:0] d);
    return (d[15:8] > d[7:0]) ? d[15:8] : d[7:0];
  endfunction
endpackage

// File: rtl/snd_voice_dec.sv
module snd_voice_dec #(
  parameter int VOICES_PER_WIN = 32,
  parameter int STRIDE_W       = 7,
  localparam int NV    = 2 * VOICES_PER_WIN,
  localparam int VID_W = $clog2(NV),
  localparam int OFF_W = $clog2(VOICES_PER_WIN) + STRIDE_W
) (
  input  logic                wr_en_i,
  input  logic                win_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [NV-1:0]       sel_o,
  output logic [STRIDE_W-1:0] reg_o,
  output logic [VID_W-1:0]    voice_o
);
  assign reg_o   = off_i[STRIDE_W-1:0];
  assign voice_o = {win_i, off_i[OFF_W-1:STRIDE_W]};

  for (genvar g = 0; g < NV; g++) begin : g_sel
    assign sel_o[g] = wr_en_i && (voice_o == VID_W'(g));
  end
endmodule

// File: rtl/snd_rate_conv.sv
module snd_rate_conv #(
  parameter int VID_W     = 6,
  parameter int RATE_W    = 24,
  parameter int BASE_RATE = 44100,
  localparam int MANT_W = 10,
  localparam int PROD_W = RATE_W + MANT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [VID_W-1:0]  voice_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [2:0]        exp_i,
  input  logic              neg_i,
  output logic              s1_vld_o,
  output logic [VID_W-1:0]  s1_voice_o,
  output logic              vld_o,
  output logic [VID_W-1:0]  voice_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [MANT_W-1:0] s1_mant;
  logic [2:0]        s1_exp, s2_exp;
  logic              s1_neg, s2_neg;
  logic [PROD_W-1:0] s2_prod;

  // stage 1: capture pitch fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o   <= 1'b0;
      s1_voice_o <= '0;
      s1_mant    <= '0;
      s1_exp     <= '0;
      s1_neg     <= 1'b0;
    end else begin
      s1_vld_o <= vld_i;
      if (vld_i) begin
        s1_voice_o <= voice_i;
        s1_mant    <= mant_i;
        s1_exp     <= exp_i;
        s1_neg     <= neg_i;
      end
    end
  end

  // stage 2: multiply by base rate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      voice_o <= '0;
      s2_prod <= '0;
      s2_exp  <= '0;
      s2_neg  <= 1'b0;
    end else begin
      vld_o <= s1_vld_o;
      if (s1_vld_o) begin
        voice_o <= s1_voice_o;
        s2_prod <= PROD_W'(BASE_RATE) * PROD_W'(s1_mant);
        s2_exp  <= s1_exp;
        s2_neg  <= s1_neg;
      end
    end
  end

  // stage 3 (combinational, registered by the voice slot): shift and add
  logic [RATE_W-1:0] base_w;
  logic [3:0]        nshift;
  logic [PROD_W-1:0] frac;
  logic [RATE_W-1:0] whole;

  assign base_w = RATE_W'(BASE_RATE);
  assign nshift = 4'd8 - {1'b0, s2_exp};

  always_comb begin
    if (s2_neg) begin
      whole = base_w >> nshift;
      frac  = s2_prod >> ({1'b0, nshift} + 5'd10);
    end else begin
      whole = base_w << s2_exp;
      frac  = s2_prod >> (5'd10 - {2'b0, s2_exp});
    end
    rate_o = whole + frac[RATE_W-1:0];
  end
endmodule

// File: rtl/snd_voice_slot.sv
module snd_voice_slot
  import snd_voice_pkg::*;
#(
  parameter int RATE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [STRIDE_W-1:0] reg_i,
  input  logic [15:0]         data_i,
  input  logic                rate_we_i,
  input  logic                rate_set_i,
  input  logic [RATE_W-1:0]   rate_i,
  output logic                key_o,
  output logic [ADDR_W-1:0]   start_addr_o,
  output logic                loop_en_o,
  output logic [1:0]          fmt_o,
  output logic [HALF_W-1:0]   loop_start_o,
  output logic [HALF_W-1:0]   loop_end_o,
  output logic [RATE_W-1:0]   rate_o,
  output logic                rate_vld_o,
  output logic [PAN_W-1:0]    pan_o,
  output logic [LVL_W-1:0]    level_o
);
  smp_fmt_e fmt_q;
  logic     pitch_wr;

  assign fmt_o    = fmt_q;
  assign pitch_wr = we_i && (reg_i == REG_PITCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o        <= 1'b0;
      start_addr_o <= '0;
      loop_en_o    <= 1'b0;
      fmt_q        <= FMT_PCM16;
      loop_start_o <= '0;
      loop_end_o   <= '0;
      rate_o       <= '0;
      rate_vld_o   <= 1'b0;
      pan_o        <= '0;
      level_o      <= '0;
    end else begin
      if (we_i) begin
        case (reg_i)
          REG_CFG: begin
            start_addr_o[20:16] <= data_i[4:0];
            loop_en_o           <= data_i[9];
            fmt_q               <= fmt_decode(data_i[8:7]);
            key_o               <= data_i[14];
          end
          REG_SA_LO:  start_addr_o[15:0] <= data_i;
          REG_LSTART: loop_start_o       <= data_i;
          REG_LEND:   loop_end_o         <= data_i;
          REG_PAN:    pan_o              <= pan_map(data_i[4:0]);
          REG_LEVEL:  level_o            <= level_pick(data_i);
          default: ;
        endcase
      end
      if (rate_we_i) rate_o <= rate_i;
      if (pitch_wr)        rate_vld_o <= 1'b0;
      else if (rate_set_i) rate_vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/snd_voice_regs.sv
module snd_voice_regs
  import snd_voice_pkg::*;
#(
  parameter int VOICES_PER_WIN = 32,
  parameter int RATE_W         = 24,
  parameter int BASE_RATE      = 44100,
  localparam int NV    = 2 * VOICES_PER_WIN,
  localparam int VID_W = $clog2(NV),
  localparam int OFF_W = $clog2(VOICES_PER_WIN) + STRIDE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   wr_win_i,
  input  logic [OFF_W-1:0]       wr_off_i,
  input  logic [15:0]            wr_data_i,
  output logic [NV*ADDR_W-1:0]   start_addr_o,
  output logic [NV-1:0]          loop_en_o,
  output logic [NV*2-1:0]        fmt_o,
  output logic [NV*HALF_W-1:0]   loop_start_o,
  output logic [NV*HALF_W-1:0]   loop_end_o,
  output logic [NV*RATE_W-1:0]   rate_o,
  output logic [NV-1:0]          rate_vld_o,
  output logic [NV*PAN_W-1:0]    pan_o,
  output logic [NV*LVL_W-1:0]    level_o,
  output logic [NV-1:0]          run_o,
  output logic [NV-1:0]          key_start_o,
  output logic [NV-1:0]          key_stop_o
);
  logic [NV-1:0]       sel;
  logic [STRIDE_W-1:0] reg_sel;
  logic [VID_W-1:0]    voice;

  snd_voice_dec #(
    .VOICES_PER_WIN(VOICES_PER_WIN),
    .STRIDE_W      (STRIDE_W)
  ) u_dec (
    .wr_en_i(wr_en_i),
    .win_i  (wr_win_i),
    .off_i  (wr_off_i),
    .sel_o  (sel),
    .reg_o  (reg_sel),
    .voice_o(voice)
  );

  logic              cv_s1_vld, cv_vld;
  logic [VID_W-1:0]  cv_s1_voice, cv_voice;
  logic [RATE_W-1:0] cv_rate;

  snd_rate_conv #(
    .VID_W    (VID_W),
    .RATE_W   (RATE_W),
    .BASE_RATE(BASE_RATE)
  ) u_conv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (wr_en_i && (reg_sel == REG_PITCH)),
    .voice_i   (voice),
    .mant_i    (wr_data_i[9:0]),
    .exp_i     (wr_data_i[13:11]),
    .neg_i     (wr_data_i[14]),
    .s1_vld_o  (cv_s1_vld),
    .s1_voice_o(cv_s1_voice),
    .vld_o     (cv_vld),
    .voice_o   (cv_voice),
    .rate_o    (cv_rate)
  );

  logic [NV-1:0] key_q;
  logic [NV-1:0] key_now;
  logic          trig;

  assign trig = wr_en_i && (reg_sel == REG_CFG) && wr_data_i[15];

  for (genvar v = 0; v < NV; v++) begin : g_voice
    logic rate_we, rate_set;
    // a newer pitch write in stage 1 supersedes the result landing now
    assign rate_we  = cv_vld && (cv_voice == VID_W'(v));
    assign rate_set = rate_we && !(cv_s1_vld && (cv_s1_voice == VID_W'(v)));
    // the triggering write's own key bit counts
    assign key_now[v] = (sel[v] && (reg_sel == REG_CFG)) ? wr_data_i[14] : key_q[v];

    snd_voice_slot #(.RATE_W(RATE_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (sel[v]),
      .reg_i       (reg_sel),
      .data_i      (wr_data_i),
      .rate_we_i   (rate_we),
      .rate_set_i  (rate_set),
      .rate_i      (cv_rate),
      .key_o       (key_q[v]),
      .start_addr_o(start_addr_o[v*ADDR_W +: ADDR_W]),
      .loop_en_o   (loop_en_o[v]),
      .fmt_o       (fmt_o[v*2 +: 2]),
      .loop_start_o(loop_start_o[v*HALF_W +: HALF_W]),
      .loop_end_o  (loop_end_o[v*HALF_W +: HALF_W]),
      .rate_o      (rate_o[v*RATE_W +: RATE_W]),
      .rate_vld_o  (rate_vld_o[v]),
      .pan_o       (pan_o[v*PAN_W +: PAN_W]),
      .level_o     (level_o[v*LVL_W +: LVL_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o       <= '0;
      key_start_o <= '0;
      key_stop_o  <= '0;
    end else begin
      key_start_o <= trig ? key_now  : '0;
      key_stop_o  <= trig ? ~key_now : '0;
      if (trig) run_o <= key_now;
    end
  end
endmodule

// File: rtl/snd_voice_regs_chk.sv
module snd_voice_regs_chk #(
  parameter int VOICES_PER_WIN = 32,
  localparam int NV    = 2 * VOICES_PER_WIN,
  localparam int VID_W = $clog2(NV),
  localparam int OFF_W = $clog2(VOICES_PER_WIN) + 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_win_i,
  input logic [OFF_W-1:0] wr_off_i,
  input logic [NV-1:0]    rate_vld_o,
  input logic [NV-1:0]    run_o,
  input logic [NV-1:0]    key_start_o,
  input logic [NV-1:0]    key_stop_o
);
  logic             pw_q, pw2_q, pw3_q;
  logic [VID_W-1:0] pv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q  <= 1'b0;
      pw2_q <= 1'b0;
      pw3_q <= 1'b0;
      pv_q  <= '0;
    end else begin
      pw_q  <= wr_en_i && (wr_off_i[6:0] == 7'h18);
      pw2_q <= pw_q;
      pw3_q <= pw2_q;
      pv_q  <= {wr_win_i, wr_off_i[OFF_W-1:7]};
    end
  end

  assert_sweep_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(key_start_o | key_stop_o) == 0) ||
    ($countones(key_start_o | key_stop_o) == NV));

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_start_o & key_stop_o) == '0);

  assert_run_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|key_stop_o) |-> (run_o == key_start_o));

  assert_run_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((key_start_o | key_stop_o) == '0) |-> $stable(run_o));

  assert_vld_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_q |-> !rate_vld_o[pv_q]);

  assert_vld_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rate_vld_o & ~$past(rate_vld_o))) |-> pw3_q);
endmodule

bind snd_voice_regs snd_voice_regs_chk #(.VOICES_PER_WIN(VOICES_PER_WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_win_i   (wr_win_i),
  .wr_off_i   (wr_off_i),
  .rate_vld_o (rate_vld_o),
  .run_o      (run_o),
  .key_start_o(key_start_o),
  .key_stop_o (key_stop_o)
);

// File: tb/snd_voice_regs_test.sv
`timescale 1ns/1ps
module snd_voice_regs_test;
  localparam int NV = 64;
  localparam int RW = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, wr_win_i = 1'b0;
  logic [11:0] wr_off_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [NV*21-1:0] start_addr_o;
  logic [NV-1:0]    loop_en_o, rate_vld_o, run_o, key_start_o, key_stop_o;
  logic [NV*2-1:0]  fmt_o;
  logic [NV*16-1:0] loop_start_o, loop_end_o;
  logic [NV*RW-1:0] rate_o;
  logic [NV*5-1:0]  pan_o;
  logic [NV*8-1:0]  level_o;

  always #2.5 clk = ~clk;

  snd_voice_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_win_i(wr_win_i),
    .wr_off_i(wr_off_i), .wr_data_i(wr_data_i), .start_addr_o(start_addr_o),
    .loop_en_o(loop_en_o), .fmt_o(fmt_o), .loop_start_o(loop_start_o),
    .loop_end_o(loop_end_o), .rate_o(rate_o), .rate_vld_o(rate_vld_o),
    .pan_o(pan_o), .level_o(level_o), .run_o(run_o),
    .key_start_o(key_start_o), .key_stop_o(key_stop_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [11:0] off, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_win_i = win; wr_off_i = off; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // field codes: 0 start,1 loop,2 fmt,3 lstart,4 lend,5 pan,6 level,7 rate
  function automatic logic [23:0] fetch(input int v, input int f);
    case (f)
      0: return 24'(start_addr_o[v*21 +: 21]);
      1: return 24'(loop_en_o[v]);
      2: return 24'(fmt_o[v*2 +: 2]);
      3: return 24'(loop_start_o[v*16 +: 16]);
      4: return 24'(loop_end_o[v*16 +: 16]);
      5: return 24'(pan_o[v*5 +: 5]);
      6: return 24'(level_o[v*8 +: 8]);
      default: return rate_o[v*RW +: RW];
    endcase
  endfunction

  // {win, offset, data, field, expected}
  localparam int NVEC = 20;
  localparam logic [55:0] VEC [NVEC] = '{
    {1'b0, 12'h000, 16'h001F, 3'd0, 24'h1F0000},  // R2 start hi, voice 0
    {1'b0, 12'h004, 16'hABCD, 3'd0, 24'h1FABCD},  // R2 start lo
    {1'b1, 12'h080, 16'h0280, 3'd2, 24'h000001},  // R1 R3 voice 33, 8-bit
    {1'b1, 12'h080, 16'h0280, 3'd1, 24'h000001},  // R2 loop enable
    {1'b0, 12'h100, 16'h0180, 3'd2, 24'h000002},  // R3 code 3 -> adpcm
    {1'b0, 12'h100, 16'h0100, 3'd2, 24'h000002},  // R3 code 2 -> adpcm
    {1'b0, 12'h100, 16'h0100, 3'd1, 24'h000000},  // R2 loop off
    {1'b0, 12'h108, 16'h1234, 3'd3, 24'h001234},  // R4 loop start
    {1'b1, 12'hF8C, 16'hFFFF, 3'd4, 24'h00FFFF},  // R1 R4 voice 63 loop end
    {1'b0, 12'h0A4, 16'h0003, 3'd5, 24'h00000C},  // R7
    {1'b0, 12'h0A4, 16'h000F, 3'd5, 24'h000000},  // R7 boundary 15
    {1'b0, 12'h0A4, 16'h0010, 3'd5, 24'h000010},  // R7 boundary 16
    {1'b0, 12'h0A4, 16'hFFFF, 3'd5, 24'h00001F},  // R7 upper bits ignored
    {1'b0, 12'h0A8, 16'h3C81, 3'd6, 24'h000081},  // R8 low byte larger
    {1'b0, 12'h0A8, 16'h7F20, 3'd6, 24'h00007F},  // R8 high byte larger
    {1'b0, 12'h098, 16'h0000, 3'd7, 24'h00AC44},  // R5 base
    {1'b0, 12'h098, 16'h0A00, 3'd7, 24'h0204CC},  // R5 e=1 m=512
    {1'b0, 12'h098, 16'h7800, 3'd7, 24'h005622},  // R5 neg e=7
    {1'b0, 12'h098, 16'h43FF, 3'd7, 24'h000158},  // R5 neg e=0 m=1023
    {1'b1, 12'h418, 16'h3BFF, 3'd7, 24'hAC2E77}   // R5 e=7 m=1023 voice 40
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 run", 64'(run_o), 0);
    chk("R11 vld", 64'(rate_vld_o), 0);
    chk("R11 strobes", 64'(key_start_o | key_stop_o), 0);
    chk("R11 start", 64'(|start_addr_o), 0);
    chk("R11 rate", 64'(|rate_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [55:0] e;
      int v;
      e = VEC[i];
      v = (e[55] ? 32 : 0) + int'(e[54:43] >> 7);
      wr(e[55], e[54:43], e[42:27]);
      repeat (2) @(negedge clk);
      chk($sformatf("vec%0d voice%0d field%0d", i, v, e[26:24]),
          64'(fetch(v, int'(e[26:24]))), 64'(e[23:0]));
    end
    chk("R6 vld voice40", 64'(rate_vld_o[40]), 1);

    // R10 unlisted offset, all ones
    wr(1'b0, 12'h110, 16'hFFFF);
    chk("R10 no strobe", 64'(key_start_o | key_stop_o), 0);
    repeat (2) @(negedge clk);
    chk("R10 lstart", 64'(fetch(2, 3)), 64'h1234);
    chk("R10 lend", 64'(fetch(2, 4)), 0);
    chk("R10 fmt", 64'(fetch(2, 2)), 2);
    chk("R10 pan", 64'(fetch(2, 5)), 0);

    // R9 key sweep
    wr(1'b0, 12'h280, 16'h4000);  // voice 5 key, no trigger
    chk("R9 no trig strobe", 64'(key_start_o | key_stop_o), 0);
    chk("R9 no trig run", 64'(run_o), 0);
    wr(1'b0, 12'h480, 16'hC000);  // voice 9 key + trigger
    chk("R9 start", 64'(key_start_o), 64'h0000_0000_0000_0220);
    chk("R9 stop", 64'(key_stop_o), ~64'h0000_0000_0000_0220);
    chk("R9 run", 64'(run_o), 64'h0000_0000_0000_0220);
    @(negedge clk);
    chk("R9 strobe pulse", 64'(key_start_o | key_stop_o), 0);
    chk("R9 run hold", 64'(run_o), 64'h0000_0000_0000_0220);
    wr(1'b0, 12'h480, 16'h8000);  // voice 9 key off + trigger
    chk("R9 start2", 64'(key_start_o), 64'h0000_0000_0000_0020);
    chk("R9 run2", 64'(run_o), 64'h0000_0000_0000_0020);

    // R6 valid timing, voice 3
    wr(1'b0, 12'h198, 16'h0000);
    chk("R6 vld low", 64'(rate_vld_o[3]), 0);
    @(negedge clk);
    chk("R6 vld still low", 64'(rate_vld_o[3]), 0);
    @(negedge clk);
    chk("R6 vld high", 64'(rate_vld_o[3]), 1);
    chk("R6 rate", 64'(fetch(3, 7)), 64'hAC44);

    // R6 back-to-back pitch writes to voice 3
    @(negedge clk);
    wr_en_i = 1'b1; wr_win_i = 1'b0; wr_off_i = 12'h198; wr_data_i = 16'h7800;
    @(negedge clk);
    wr_data_i = 16'h0A00;
    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    chk("R6 older result no vld", 64'(rate_vld_o[3]), 0);
    @(negedge clk);
    chk("R6 newer vld", 64'(rate_vld_o[3]), 1);
    chk("R6 newer rate", 64'(fetch(3, 7)), 64'h204CC);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule